// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block is the master-side sender of a two-channel serial audio link. It runs on the bit clock. From that clock it produces a word-select line that is low for one half of each frame and high for the other, and it shifts a left sample and a right sample onto a serial data line, one per half. Software, or a neighbouring block, sets the length of each half frame in bit clocks and the sample width. A single control picks where the first bit of each sample falls: one bit clock after the word-select change, which is the classic I2S placement, or on the same bit clock as that change, which is MSB-aligned.

The data line comes with an output enable. The enable is high only while sample bits are being sent, so the pad can float for the rest of each half. Both samples come from holding inputs. The block copies them at the start of every frame and raises a one-cycle frame pulse at that point, which tells the source to present the next pair. The word-select line, the data line, the enable and the pulse all change on the falling bit-clock edge, so a receiver can sample them on the rising edge.

Top module: `i2s_tx`

## Requirements
- R1: `ws` toggles every `half_len` bit clocks, so each frame is low for `half_len` cycles and then high for `half_len` cycles (50% duty). `half_len` ranges from 5 to 63.
- R2: The left sample is sent while `ws` is low and the right sample while `ws` is high.
- R3: With `justify` = 0, the MSB appears one bit clock after each `ws` transition, and `sd_oe` is low in the transition cycle. In this mode `word_len` must be less than `half_len`.
- R4: With `justify` = 1, the MSB appears in the same bit clock as each `ws` transition. `word_len` may equal `half_len`.
- R5: Each sample is sent MSB first and is exactly `word_len` bits long, with `word_len` from 4 to 16. The sample is taken from bits `word_len-1` down to 0 of its holding input.
- R6: `sd_oe` is high only while a sample bit is on `sd`. In the remaining cycles of each half, `sd_oe` is low and `sd` is 0.
- R7: `frame_irq` is a one-cycle pulse on each frame start, in the cycle where `ws` falls. There is exactly one pulse per frame, and none for the first frame after reset.
- R8: Both `left_word` and `right_word` are captured at the frame start. A change to either input after that point first shows up in the next frame.
- R9: While `rst_n` is low: `ws` = 1, `sd` = 0, `sd_oe` = 0 and `frame_irq` = 0. The first falling bit-clock edge after release begins a left half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | Bit clock; outputs change on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_len | input | CNT_W | Bit clocks per half frame |
| word_len | input | WL_W | Sample width in bits (4..MAX_WORD) |
| justify | input | 1 | 0: MSB one clock after ws edge; 1: MSB on the ws edge |
| left_word | input | MAX_WORD | Left holding input |
| right_word | input | MAX_WORD | Right holding input |
| ws | output | 1 | Word select / frame sync, low = left |
| sd | output | 1 | Serial data |
| sd_oe | output | 1 | Data pad drive enable |
| frame_irq | output | 1 | One-cycle pulse per frame start |

## Verification
The bench decodes the serial stream the way a receiver would. It records where the first enabled bit falls relative to each `ws` edge, so a design that ignored `justify` or slipped by one cycle shows the MSB at the wrong offset. It runs a short sample inside a longer half frame. A design that kept driving past the LSB then reports too many bits, and one that cut the sample short returns a truncated value. It changes the right holding input in the middle of a frame. A design that read the right sample at the half boundary, rather than at the frame start, then sends the new value one frame too early. It also counts frame pulses over several frames and confirms that no pulse comes at the first frame after reset, which catches a pulse on every `ws` edge or a spurious start-up pulse.

// File: rtl/i2s_tx.sv
module i2s_tx #(
  parameter int MAX_WORD = 16,
  parameter int CNT_W    = 6,
  localparam int WL_W    = $clog2(MAX_WORD + 1)
) (
  input  logic                bck,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    half_len,
  input  logic [WL_W-1:0]     word_len,
  input  logic                justify,
  input  logic [MAX_WORD-1:0] left_word,
  input  logic [MAX_WORD-1:0] right_word,
  output logic                ws,
  output logic                sd,
  output logic                sd_oe,
  output logic                frame_irq
);

  logic [CNT_W-1:0]    cnt;
  logic                first;
  logic [MAX_WORD-1:0] cur, held_r;

  wire                wrap        = first | (cnt == half_len - 1'b1);
  wire [CNT_W-1:0]    pos         = wrap ? '0 : cnt + 1'b1;
  wire                frame_start = wrap & ws;
  wire [MAX_WORD-1:0] word        = !wrap ? cur : (ws ? left_word : held_r);

  wire [CNT_W-1:0]    lag     = justify ? pos : pos - 1'b1;
  wire                in_word = (justify || pos != '0) && (lag < CNT_W'(word_len));
  wire [WL_W-1:0]     idx     = word_len - WL_W'(1) - lag[WL_W-1:0];
  wire [MAX_WORD-1:0] shifted = word >> idx;

  always_ff @(negedge bck or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      first     <= 1'b1;
      ws        <= 1'b1;
      sd        <= 1'b0;
      sd_oe     <= 1'b0;
      frame_irq <= 1'b0;
      cur       <= '0;
      held_r    <= '0;
    end else begin
      first     <= 1'b0;
      cnt       <= pos;
      if (wrap) ws <= ~ws;
      frame_irq <= frame_start & ~first;
      if (wrap) cur <= word;
      if (frame_start) held_r <= right_word;
      sd        <= in_word & shifted[0];
      sd_oe     <= in_word;
    end
  end

endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk #(
  parameter int MAX_WORD = 16,
  parameter int CNT_W    = 6,
  localparam int WL_W    = $clog2(MAX_WORD + 1)
) (
  input logic             bck,
  input logic             rst_n,
  input logic [CNT_W-1:0] half_len,
  input logic [WL_W-1:0]  word_len,
  input logic             justify,
  input logic             ws,
  input logic             sd_oe,
  input logic             frame_irq
);

  logic             ws_q, seen_q;
  logic [CNT_W-1:0] since_q;
  logic [CNT_W:0]   oe_q;

  wire              tog    = ws != ws_q;
  wire [CNT_W:0]    oe_now = tog ? (CNT_W+1)'(sd_oe) : oe_q + (CNT_W+1)'(sd_oe);

  always_ff @(negedge bck or negedge rst_n) begin
    if (!rst_n) begin
      ws_q    <= 1'b1;
      seen_q  <= 1'b0;
      since_q <= '0;
      oe_q    <= '0;
    end else begin
      ws_q    <= ws;
      seen_q  <= seen_q | tog;
      since_q <= tog ? '0 : since_q + 1'b1;
      oe_q    <= oe_now;
    end
  end

  // R1
  ws_period_chk: assert property (@(negedge bck) disable iff (!rst_n)
    (tog && seen_q) |-> (since_q == half_len - 1'b1));

  // R1
  ws_hold_chk: assert property (@(negedge bck) disable iff (!rst_n)
    (!tog && seen_q) |-> (since_q != half_len - 1'b1));

  // R3
  std_gap_chk: assert property (@(negedge bck) disable iff (!rst_n)
    (tog && !justify) |-> !sd_oe);

  // R4
  just_msb_chk: assert property (@(negedge bck) disable iff (!rst_n)
    (tog && justify) |-> sd_oe);

  // R6
  oe_len_chk: assert property (@(negedge bck) disable iff (!rst_n)
    oe_now <= (CNT_W+1)'(word_len));

  // R7
  irq_place_chk: assert property (@(negedge bck) disable iff (!rst_n)
    frame_irq |-> (tog && !ws));

endmodule

bind i2s_tx i2s_tx_chk #(.MAX_WORD(MAX_WORD), .CNT_W(CNT_W)) i_chk (
  .bck(bck), .rst_n(rst_n), .half_len(half_len), .word_len(word_len),
  .justify(justify), .ws(ws), .sd_oe(sd_oe), .frame_irq(frame_irq)
);

// File: tb/test_i2s_tx.sv
`timescale 1ns/1ps
module test_i2s_tx;
  logic        bck = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  half_len = 6'd17;
  logic [4:0]  word_len = 5'd16;
  logic        justify = 1'b0;
  logic [15:0] left_word = '0, right_word = '0;
  logic        ws, sd, sd_oe, frame_irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 bck = ~bck;

  i2s_tx i_i2s_tx (.bck(bck), .rst_n(rst_n), .half_len(half_len), .word_len(word_len),
    .justify(justify), .left_word(left_word), .right_word(right_word),
    .ws(ws), .sd(sd), .sd_oe(sd_oe), .frame_irq(frame_irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int hl, input int wl, input bit j);
    rst_n = 1'b0;
    half_len = 6'(hl); word_len = 5'(wl); justify = j;
    repeat (3) @(posedge bck);
  endtask

  // returns at the posedge of a left half's first cycle
  task automatic sync_left();
    logic prev = ws;
    for (int n = 0; n < 300; n++) begin
      @(posedge bck);
      if (prev && !ws) return;
      prev = ws;
    end
  endtask

  task automatic sample_half(output logic side, output int val, output int nbits,
                             output int first_pos, output int hlen, output int sd_stray);
    side = ws; val = 0; nbits = 0; first_pos = -1; hlen = 0; sd_stray = 0;
    while (ws == side && hlen < 200) begin
      if (sd_oe) begin
        if (first_pos < 0) first_pos = hlen;
        val = (val << 1) | int'(sd);
        nbits++;
      end else if (sd) sd_stray++;
      hlen++;
      @(posedge bck);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge bck);
    chk(ws === 1'b1, "R9 ws", int'(ws), 1);
    chk(sd_oe === 1'b0 && sd === 1'b0, "R9 sd/oe", int'(sd_oe), 0);
    chk(frame_irq === 1'b0, "R9 irq", int'(frame_irq), 0);
    rst_n = 1'b1;
    @(posedge bck);
    chk(ws === 1'b0, "R9 first half is left", int'(ws), 0);
  endtask

  task automatic t_mode(input int hl, input int wl, input bit j, input int l, input int r);
    logic side; int v, nb, fp, hlen, st;
    int mask = (1 << wl) - 1;
    do_reset(hl, wl, j);
    left_word = 16'(l); right_word = 16'(r);
    rst_n = 1'b1;
    sync_left();
    for (int f = 0; f < 2; f++) begin
      for (int h = 0; h < 2; h++) begin
        sample_half(side, v, nb, fp, hlen, st);
        chk(hlen == hl, "R1 half length", hlen, hl);
        chk(side == logic'(h), "R2 ws level", int'(side), h);
        chk(v == ((h == 0 ? l : r) & mask), "R5 value", v, (h == 0 ? l : r) & mask);
        chk(nb == wl, "R6 driven bits", nb, wl);
        chk(st == 0, "R6 sd low while undriven", st, 0);
        if (j) chk(fp == 0, "R4 MSB offset", fp, 0);
        else   chk(fp == 1, "R3 MSB offset", fp, 1);
      end
    end
  endtask

  task automatic t_latch();
    logic side; int v, nb, fp, hlen, st;
    do_reset(12, 10, 1'b0);
    left_word = 16'h0155; right_word = 16'h02AA;
    rst_n = 1'b1;
    sync_left();
    left_word = 16'h0033; right_word = 16'h03C3;
    sample_half(side, v, nb, fp, hlen, st);
    chk(v == 'h155, "R8 left held", v, 'h155);
    sample_half(side, v, nb, fp, hlen, st);
    chk(v == 'h2AA, "R8 right held", v, 'h2AA);
    sample_half(side, v, nb, fp, hlen, st);
    chk(v == 'h033, "R8 new left", v, 'h033);
    sample_half(side, v, nb, fp, hlen, st);
    chk(v == 'h3C3, "R8 new right", v, 'h3C3);
  endtask

  task automatic t_irq();
    int cnt = 0, bad = 0;
    do_reset(8, 6, 1'b1);
    rst_n = 1'b1;
    @(posedge bck);
    chk(frame_irq === 1'b0, "R7 no pulse at first frame", int'(frame_irq), 0);
    sync_left();
    for (int n = 0; n < 3 * 16; n++) begin
      if (frame_irq) begin
        cnt++;
        if (ws !== 1'b0 || n % 16 != 0) bad++;
      end
      @(posedge bck);
    end
    chk(cnt == 3, "R7 pulses per three frames", cnt, 3);
    chk(bad == 0, "R7 pulse placement", bad, 0);
  endtask

  initial begin
    t_reset();
    t_mode(17, 16, 1'b0, 'hA53C, 'h5AC3);
    t_mode(16, 16, 1'b1, 'h8001, 'h7FFE);
    t_mode(12, 8, 1'b0, 'hFF96, 'h0069);
    t_mode(9, 4, 1'b1, 'h000B, 'h0004);
    t_latch();
    t_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule